// File: doc/BRIEF.md
# Converter Register Serial Programmer

This block sets up three analog front-end converters, one per colour channel, over a three-wire serial link. The converters share one serial clock and one data line. Each has its own active-low load strobe. When reset is released, the block writes a fixed default value into every register of every converter. It drives all three strobes together, so each default frame is sent only once and reaches all three converters.

After the defaults are written, an operator can change a single register. The operator sets an address and a data byte on switches, picks the target converters with three enable inputs, and presses an adjust button. The button goes through a synchroniser and a debouncer. The rising edge of the clean level starts one frame, which is sent only to the converters whose enable bit is set.

An external mode hands the three serial wires to outside equipment. In that mode the converter lines follow the external inputs, and the button has no effect.

Top module: `afe_serial_loader`

## Requirements
- R1: While reset is asserted, all load strobes are high, SCLK is high and busy is high.
- R2: After reset is released, eight frames go out for addresses 0 to 7 in ascending order, each with all three strobes low. The data is 0x32 for address 0, 0x09 for address 1, and 0x00 for addresses 2 to 7.
- R3: A frame carries 12 bits, most significant bit first, in this order: a read/write bit that is 0 (write), then address bits A2, A1, A0, then data bits D7 down to D0.
- R4: SCLK runs at the system clock divided by 8 and rests high between frames. SDATA changes only while SCLK is low and holds steady across each rising edge. A strobe stays low for exactly 96 system clock cycles, which covers 12 rising edges of SCLK.
- R5: Between two frames, every strobe is high for at least 8 system clock cycles.
- R6: In internal mode and while idle, a debounced press writes the switch address and data to each converter whose enable bit is set. The strobe for enable bit 0 is sload_n[0] (red), bit 1 is sload_n[1] (green), and bit 2 is sload_n[2] (blue). Strobes of converters that are not selected stay high.
- R7: A press with all three enable bits at zero sends no frame, and busy stays low.
- R8: A press whose debounced edge arrives while a frame is in progress is dropped. No frame follows it.
- R9: Busy is high from reset until the last default frame and its gap are done. Busy is high during every adjust frame. Busy is low when idle.
- R10: With ext_mode high, SCLK, SDATA and the three strobes follow ext_sclk, ext_sdata and ext_sload_n at once, and a button press starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous board reset |
| ext_mode | input | 1 | 1 hands the serial lines to the external inputs |
| ext_sclk | input | 1 | External serial clock |
| ext_sdata | input | 1 | External serial data |
| ext_sload_n | input | 3 | External load strobes: bit 0 red, bit 1 green, bit 2 blue |
| adj_btn | input | 1 | Raw adjust button, asynchronous, active high |
| sw_addr | input | 3 | Register address from the switches |
| sw_data | input | 8 | Register data from the switches |
| ch_en | input | 3 | Converter select for adjust writes: bit 0 red, bit 1 green, bit 2 blue |
| sclk | output | 1 | Serial clock to the converters |
| sdata | output | 1 | Serial data to the converters |
| sload_n | output | 3 | Active-low load strobes, one per converter |
| busy | output | 1 | High while a default sequence or an adjust write is in progress |

## Verification
The bench decodes every frame on the serial lines and checks each one against a queue of expected frames. It checks the bit order, the strobe mask, the strobe-low time of 96 cycles and the gap between frames. A design that sends the address in the wrong order, or shifts on the wrong SCLK edge, shows a word mismatch. A design that skips a default register shows a missing frame.

The bench presses the button with no channel enabled, and again in the middle of a running frame. A design that queues presses, or ignores the enable bits, sends a frame that was never expected.

The bench also asserts reset again while the block is idle, and it toggles the external lines through several patterns. A design that runs the defaults only once, or delays the pass-through path, fails these checks.

// File: rtl/afe_serial_loader.sv
module afe_serial_loader #(
  parameter int NCH = 3,
  parameter int AW = 3,
  parameter int DW = 8,
  parameter int DIV = 8,
  parameter int GAP_CLKS = 8,
  parameter int DEB_LEN = 16,
  parameter logic [DW-1:0] CFG_DEFAULT = 8'h32,
  parameter logic [DW-1:0] MUX_DEFAULT = 8'h09
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ext_mode,
  input  logic           ext_sclk,
  input  logic           ext_sdata,
  input  logic [NCH-1:0] ext_sload_n,
  input  logic           adj_btn,
  input  logic [AW-1:0]  sw_addr,
  input  logic [DW-1:0]  sw_data,
  input  logic [NCH-1:0] ch_en,
  output logic           sclk,
  output logic           sdata,
  output logic [NCH-1:0] sload_n,
  output logic           busy
);
  localparam int FW = 1 + AW + DW;
  localparam int PW = $clog2(DIV);
  localparam int BW = $clog2(FW);
  localparam int GW = $clog2(GAP_CLKS);
  localparam int DBW = $clog2(DEB_LEN);
  localparam int LAST_REG = (1 << AW) - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_GAP} st_t;

  st_t           st;
  logic          init_run;
  logic [AW-1:0] idx;
  logic [PW-1:0] ph;
  logic [BW-1:0] bitn;
  logic [GW-1:0] gcnt;
  logic [FW-1:0] shreg;
  logic [NCH-1:0] mask;

  logic [1:0]     btn_sync;
  logic           btn_db, btn_db_q;
  logic [DBW-1:0] dcnt;
  logic           press;

  function automatic logic [DW-1:0] dflt(input logic [AW-1:0] a);
    case (a)
      AW'(0):  dflt = CFG_DEFAULT;
      AW'(1):  dflt = MUX_DEFAULT;
      default: dflt = '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_sync <= '0;
      btn_db   <= 1'b0;
      btn_db_q <= 1'b0;
      dcnt     <= '0;
    end else begin
      btn_sync <= {btn_sync[0], adj_btn};
      btn_db_q <= btn_db;
      if (btn_sync[1] == btn_db) begin
        dcnt <= '0;
      end else if (dcnt == DBW'(DEB_LEN - 1)) begin
        btn_db <= btn_sync[1];
        dcnt   <= '0;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  assign press = btn_db & ~btn_db_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_LOAD;
      init_run <= 1'b1;
      idx      <= '0;
      ph       <= '0;
      bitn     <= '0;
      gcnt     <= '0;
      shreg    <= '0;
      mask     <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (press && !ext_mode && (|ch_en)) begin
            shreg <= {1'b0, sw_addr, sw_data};
            mask  <= ch_en;
            ph    <= '0;
            bitn  <= '0;
            st    <= ST_SHIFT;
          end
        end
        ST_LOAD: begin
          shreg <= {1'b0, idx, dflt(idx)};
          mask  <= '1;
          ph    <= '0;
          bitn  <= '0;
          st    <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (ph == PW'(DIV - 1)) begin
            ph <= '0;
            if (bitn == BW'(FW - 1)) begin
              gcnt <= '0;
              st   <= ST_GAP;
            end else begin
              bitn  <= bitn + 1'b1;
              shreg <= {shreg[FW-2:0], 1'b0};
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_GAP: begin
          if (gcnt == GW'(GAP_CLKS - 1)) begin
            if (!init_run) begin
              st <= ST_IDLE;
            end else if (idx == AW'(LAST_REG)) begin
              init_run <= 1'b0;
              st       <= ST_IDLE;
            end else begin
              idx <= idx + 1'b1;
              st  <= ST_LOAD;
            end
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic shifting;
  assign shifting = (st == ST_SHIFT);
  assign busy     = (st != ST_IDLE);
  assign sclk     = ext_mode ? ext_sclk : (!shifting || (ph >= PW'(DIV / 2)));
  assign sdata    = ext_mode ? ext_sdata : (shifting & shreg[FW-1]);
  assign sload_n  = ext_mode ? ext_sload_n : (shifting ? ~mask : '1);
endmodule

// File: rtl/afe_serial_loader_chk.sv
module afe_serial_loader_chk #(
  parameter int NCH = 3,
  parameter int FRAME_CLKS = 96
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ext_mode,
  input logic           sclk,
  input logic           sdata,
  input logic [NCH-1:0] sload_n,
  input logic           busy
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (!(&sload_n)) low_cnt <= low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  AST_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && (&sload_n)) |-> sclk); // R4

  AST_SDATA_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !$past(ext_mode) && !(&sload_n) && $rose(sclk)) |-> $stable(sdata)); // R4

  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !$past(ext_mode) && (&sload_n) && !(&$past(sload_n))) |-> (low_cnt == 16'(FRAME_CLKS))); // R4

  AST_MASK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !$past(ext_mode) && !(&sload_n) && !(&$past(sload_n))) |-> (sload_n == $past(sload_n))); // R6

  AST_BUSY_DURING_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !(&sload_n)) |-> busy); // R9
endmodule

bind afe_serial_loader afe_serial_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .sclk(sclk),
  .sdata(sdata), .sload_n(sload_n), .busy(busy)
);

// File: tb/tb_afe_serial_loader.sv
`timescale 1ns/1ps
module tb_afe_serial_loader;
  localparam int DEB = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic ext_mode, ext_sclk, ext_sdata, adj_btn;
  logic [2:0] ext_sload_n, ch_en, sload_n;
  logic [2:0] sw_addr;
  logic [7:0] sw_data;
  logic sclk, sdata, busy;

  always #4 clk = ~clk;

  afe_serial_loader #(.DEB_LEN(DEB)) dut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .ext_sclk(ext_sclk),
    .ext_sdata(ext_sdata), .ext_sload_n(ext_sload_n), .adj_btn(adj_btn),
    .sw_addr(sw_addr), .sw_data(sw_data), .ch_en(ch_en),
    .sclk(sclk), .sdata(sdata), .sload_n(sload_n), .busy(busy)
  );

  int checks = 0, fails = 0, frames = 0;
  bit mon_en = 1'b1;
  string cur_tag = "R2";
  logic [14:0] exp_q[$];
  string tag_q[$];
  logic all_hi;
  assign all_hi = &sload_n;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_frame(input logic [2:0] m, input logic [2:0] a,
                              input logic [7:0] d, input string tag);
    exp_q.push_back({m, 1'b0, a, d});
    tag_q.push_back(tag);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: decode frames and compare against the queue
  initial begin
    realtime t_start, t_end;
    t_end = 0;
    forever begin
      @(negedge all_hi);
      if (mon_en) begin
        logic [2:0] m;
        logic [11:0] w;
        int n;
        string tg;
        m = ~sload_n; w = '0; n = 0;
        t_start = $realtime;
        if (t_end != 0)
          check((t_start - t_end) >= 64.0, "R5", "gap between frames ns",
                longint'(t_start - t_end), 64);
        while (!all_hi) begin
          @(posedge sclk or posedge all_hi);
          if (!all_hi) begin w = {w[10:0], sdata}; n++; end
        end
        t_end = $realtime;
        frames++;
        check(n == 12, "R4", "rising SCLK edges in frame", n, 12);
        check((t_end - t_start) == 768.0, "R4", "strobe low time ns",
              longint'(t_end - t_start), 768);
        if (exp_q.size() == 0) begin
          check(1'b0, cur_tag, "unexpected frame", {m, w}, 0);
        end else begin
          logic [14:0] e;
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(m == e[14:12], tg, "strobe mask", m, e[14:12]);
          check(w == e[11:0], "R3", "frame word", w, e[11:0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    report();
  end

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic push_defaults();
    for (int a = 0; a < 8; a++)
      expect_frame(3'b111, 3'(a), (a == 0) ? 8'h32 : (a == 1) ? 8'h09 : 8'h00, "R2");
  endtask

  task automatic press(input int hold);
    adj_btn = 1'b1;
    repeat (hold) @(negedge clk);
    adj_btn = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ext_mode = 1'b0; ext_sclk = 1'b1; ext_sdata = 1'b0;
    ext_sload_n = 3'b111; adj_btn = 1'b0; sw_addr = '0; sw_data = '0; ch_en = '0;
    push_defaults();
    repeat (5) @(negedge clk);
    check(sload_n == 3'b111, "R1", "strobes in reset", sload_n, 3'b111);
    check(sclk == 1'b1, "R1", "sclk in reset", sclk, 1);
    check(busy == 1'b1, "R1", "busy in reset", busy, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R9", "busy after reset", busy, 1);
    wait_idle();
    check(busy == 1'b0, "R9", "busy when idle", busy, 0);
    check(exp_q.size() == 0, "R2", "defaults outstanding", exp_q.size(), 0);

    // adjust writes, R6
    sw_addr = 3'd5; sw_data = 8'hA5; ch_en = 3'b010;
    expect_frame(3'b010, 3'd5, 8'hA5, "R6");
    press(DEB + 8);
    check(busy == 1'b1, "R9", "busy during adjust", busy, 1);
    wait_idle();
    sw_addr = 3'd2; sw_data = 8'h7F; ch_en = 3'b101;
    expect_frame(3'b101, 3'd2, 8'h7F, "R6");
    press(DEB + 8);
    wait_idle();
    check(exp_q.size() == 0, "R6", "adjust frames outstanding", exp_q.size(), 0);

    // no enable, R7
    begin
      int f0; bit seen;
      f0 = frames; seen = 1'b0; cur_tag = "R7";
      ch_en = 3'b000; sw_addr = 3'd3; sw_data = 8'h55;
      adj_btn = 1'b1;
      for (int i = 0; i < DEB + 40; i++) begin @(negedge clk); if (busy) seen = 1'b1; end
      adj_btn = 1'b0;
      repeat (40) @(negedge clk);
      check(!seen, "R7", "busy with no enable", seen, 0);
      check(frames == f0, "R7", "frame count", frames, f0);
    end

    // press during transfer, R8
    begin
      int f0;
      f0 = frames; cur_tag = "R8";
      ch_en = 3'b001; sw_addr = 3'd7; sw_data = 8'h3C;
      expect_frame(3'b001, 3'd7, 8'h3C, "R8");
      adj_btn = 1'b1;
      for (int i = 0; i < 200 && !busy; i++) @(negedge clk);
      adj_btn = 1'b0;
      repeat (25) @(negedge clk);
      sw_addr = 3'd1; sw_data = 8'hFF;
      adj_btn = 1'b1;
      repeat (25) @(negedge clk);
      check(busy == 1'b1, "R8", "second press inside frame", busy, 1);
      adj_btn = 1'b0;
      wait_idle();
      repeat (100) @(negedge clk);
      check(frames == f0 + 1, "R8", "frame count", frames, f0 + 1);
      check(busy == 1'b0, "R8", "busy after dropped press", busy, 0);
    end

    // board reset while idle, R2
    cur_tag = "R2";
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(sload_n == 3'b111 && busy, "R1", "strobes/busy in second reset",
          {busy, sload_n}, 4'hF);
    push_defaults();
    rst_n = 1'b1;
    wait_idle();
    check(exp_q.size() == 0, "R2", "defaults after board reset", exp_q.size(), 0);

    // external mode, R10
    begin
      int f0; bit seen;
      f0 = frames; seen = 1'b0; cur_tag = "R10";
      mon_en = 1'b0;
      ext_mode = 1'b1;
      for (int p = 0; p < 6; p++) begin
        @(negedge clk);
        ext_sclk = p[0]; ext_sdata = p[1]; ext_sload_n = 3'(p + 1);
        #1;
        check(sclk == ext_sclk && sdata == ext_sdata && sload_n == ext_sload_n,
              "R10", "pass-through", {sclk, sdata, sload_n}, {ext_sclk, ext_sdata, ext_sload_n});
      end
      ext_sload_n = 3'b111; ext_sclk = 1'b1; ch_en = 3'b111;
      adj_btn = 1'b1;
      for (int i = 0; i < DEB + 40; i++) begin @(negedge clk); if (busy) seen = 1'b1; end
      adj_btn = 1'b0;
      repeat (40) @(negedge clk);
      check(!seen, "R10", "busy from press in external mode", seen, 0);
      ext_mode = 1'b0;
      mon_en = 1'b1;
      repeat (150) @(negedge clk);
      check(sload_n == 3'b111 && sclk, "R10", "lines idle after external mode",
            {sclk, sload_n}, 4'hF);
      check(frames == f0, "R10", "frame count", frames, f0);
    end

    report();
  end
endmodule